// File: doc/BRIEF.md
# Store-Load Overlap Detector

This block remembers the stores issued in the current dispatch group and tells a scheduler whether an incoming load may touch the same bytes as one of them. It works on symbolic address operands, not on computed effective addresses. Every store is described by a pair of operands: operand A, which is either a register identifier or a constant offset, and operand B, the base register. It also carries an access size code. A load is described the same way.

Each load query is compared against every recorded store in parallel. A conflict is raised on three kinds of match:
- both operand pairs are equal in the same order;
- the pairs are equal in swapped order;
- the bases are equal, both offsets are constants, and the two byte ranges overlap.

The table is emptied when the dispatch group ends. A store recorded while the table is full is dropped and leaves a sticky overflow mark.

Top module: `store_overlap_detector`

## Requirements
- R1: After reset, `conflict` and `overflow` are 0 and the store table is empty.
- R2: A load whose operand A, operand B and A-is-constant flag all equal those of a recorded store gives `conflict` = 1.
- R3: A load gives `conflict` = 1 when its operand A equals a recorded store's operand B and its operand B equals that store's operand A, provided neither has operand A marked constant.
- R4: When the load base equals a recorded store's base and both have operand A marked constant, the offsets are compared as unsigned 16-bit values. If the store offset is below the load offset, there is a conflict when store offset + store size > load offset. Otherwise there is a conflict when load offset + load size > store offset. The sums are formed in 17 bits and never wrap.
- R5: The 3-bit size code maps to a byte count: 0 means 1 byte, 1 means 2, 2 means 4, 3 means 8, and codes 4 to 7 all mean 16.
- R6: `grp_clear` empties the table at the next clock edge. A load queried in the clearing cycle still sees the old table. A store recorded in the clearing cycle becomes the only entry of the new group.
- R7: While the table is empty, every load gives `conflict` = 0.
- R8: The table holds DEPTH entries (5 by default). A store recorded while the table is full, and not in a clearing cycle, is ignored and sets `overflow`. `overflow` then stays 1 until reset, even across `grp_clear`.
- R9: `conflict` is registered. It shows the result of the load presented on the previous clock edge and is 0 after any edge with `ld_valid` low.
- R10: A load queried in the same cycle as a store is recorded is not compared against that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rec_valid | input | 1 | Record a store this cycle |
| rec_opa | input | OPW | Store operand A (register id or constant offset) |
| rec_opb | input | OPW | Store operand B (base) |
| rec_size | input | 3 | Store size code (R5) |
| rec_a_const | input | 1 | Store operand A is a constant offset |
| grp_clear | input | 1 | End of dispatch group: empty the table |
| ld_valid | input | 1 | Load query this cycle |
| ld_opa | input | OPW | Load operand A |
| ld_opb | input | OPW | Load operand B (base) |
| ld_size | input | 3 | Load size code (R5) |
| ld_a_const | input | 1 | Load operand A is a constant offset |
| conflict | output | 1 | Registered conflict result |
| overflow | output | 1 | Sticky: a store was dropped because the table was full |

## Verification
A query presented in one cycle has its result on `conflict` after exactly one clock edge. A record, a clear or an overflow also takes effect at that one edge, so a store recorded in a cycle is first visible to a load in the following cycle.

The bench drives inputs on the falling edge and samples `conflict` and `overflow` on the next falling edge, half a period after the edge that updates them. It then returns the valid inputs to 0. The range rule is swept over every load offset from 0 to 31 and every load size code, against each store size. Expected values are computed arithmetically in the bench.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int unsigned SZW = 3;

  // Size code to byte count; codes at or above 4 saturate at 16 bytes.
  function automatic logic [4:0] sld_bytes(input logic [SZW-1:0] code);
    logic [4:0] b;
    case (code)
      3'd0:    b = 5'd1;
      3'd1:    b = 5'd2;
      3'd2:    b = 5'd4;
      3'd3:    b = 5'd8;
      default: b = 5'd16;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/sld_entry_cmp.sv
module sld_entry_cmp
  import sld_pkg::*;
#(
  parameter int unsigned OPW = 16
) (
  input  logic [OPW-1:0] st_a,
  input  logic [OPW-1:0] st_b,
  input  logic [SZW-1:0] st_size,
  input  logic           st_const,
  input  logic [OPW-1:0] ld_a,
  input  logic [OPW-1:0] ld_b,
  input  logic [SZW-1:0] ld_size,
  input  logic           ld_const,
  output logic           hit
);
  localparam int unsigned EW = OPW + 1;

  logic [EW-1:0] st_end;
  logic [EW-1:0] ld_end;
  logic          same_order;
  logic          swapped;
  logic          ranged;

  always_comb begin
    st_end     = {1'b0, st_a} + EW'(sld_bytes(st_size));
    ld_end     = {1'b0, ld_a} + EW'(sld_bytes(ld_size));
    same_order = (st_a == ld_a) && (st_b == ld_b) && (st_const == ld_const);
    swapped    = !st_const && !ld_const && (ld_a == st_b) && (ld_b == st_a);
    ranged     = 1'b0;
    if (st_const && ld_const && (st_b == ld_b)) begin
      if (st_a < ld_a) ranged = st_end > {1'b0, ld_a};
      else             ranged = ld_end > {1'b0, st_a};
    end
    hit = same_order || swapped || ranged;
  end
endmodule

// File: rtl/sld_table.sv
module sld_table
  import sld_pkg::*;
#(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned OPW   = 16,
  parameter int unsigned CNTW  = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rec_valid,
  input  logic [OPW-1:0]            rec_opa,
  input  logic [OPW-1:0]            rec_opb,
  input  logic [SZW-1:0]            rec_size,
  input  logic                      rec_a_const,
  input  logic                      grp_clear,
  output logic [DEPTH-1:0][OPW-1:0] tab_a,
  output logic [DEPTH-1:0][OPW-1:0] tab_b,
  output logic [DEPTH-1:0][SZW-1:0] tab_size,
  output logic [DEPTH-1:0]          tab_const,
  output logic [CNTW-1:0]           cnt,
  output logic                      ovf
);
  logic [CNTW-1:0] cnt_d;
  logic            ovf_d;
  logic            wr_en;
  logic [CNTW-1:0] wr_idx;
  logic            full;

  always_comb begin
    full   = (cnt == CNTW'(DEPTH));
    cnt_d  = cnt;
    ovf_d  = ovf;
    wr_en  = 1'b0;
    wr_idx = cnt;
    if (grp_clear) begin
      wr_idx = '0;
      wr_en  = rec_valid;
      cnt_d  = rec_valid ? CNTW'(1) : '0;
    end else if (rec_valid) begin
      if (full) begin
        ovf_d = 1'b1;
      end else begin
        wr_en = 1'b1;
        cnt_d = cnt + CNTW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      cnt <= cnt_d;
      ovf <= ovf_d;
    end
  end

  // Entry payload needs no reset: entries at or above cnt are never used.
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_en && (wr_idx == CNTW'(i));
    always_ff @(posedge clk) begin
      if (ent_we) begin
        tab_a[i]     <= rec_opa;
        tab_b[i]     <= rec_opb;
        tab_size[i]  <= rec_size;
        tab_const[i] <= rec_a_const;
      end
    end
  end
endmodule

// File: rtl/store_overlap_detector.sv
module store_overlap_detector
  import sld_pkg::*;
#(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned OPW   = 16,
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rec_valid,
  input  logic [OPW-1:0] rec_opa,
  input  logic [OPW-1:0] rec_opb,
  input  logic [2:0]     rec_size,
  input  logic           rec_a_const,
  input  logic           grp_clear,
  input  logic           ld_valid,
  input  logic [OPW-1:0] ld_opa,
  input  logic [OPW-1:0] ld_opb,
  input  logic [2:0]     ld_size,
  input  logic           ld_a_const,
  output logic           conflict,
  output logic           overflow
);
  logic [1:0] rst_sync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  logic [DEPTH-1:0][OPW-1:0] tab_a;
  logic [DEPTH-1:0][OPW-1:0] tab_b;
  logic [DEPTH-1:0][SZW-1:0] tab_size;
  logic [DEPTH-1:0]          tab_const;
  logic [CNTW-1:0]           st_cnt;
  logic [DEPTH-1:0]          hit_vec;
  logic                      conflict_d;

  sld_table #(.DEPTH(DEPTH), .OPW(OPW), .CNTW(CNTW)) u_table (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .rec_valid  (rec_valid),
    .rec_opa    (rec_opa),
    .rec_opb    (rec_opb),
    .rec_size   (rec_size),
    .rec_a_const(rec_a_const),
    .grp_clear  (grp_clear),
    .tab_a      (tab_a),
    .tab_b      (tab_b),
    .tab_size   (tab_size),
    .tab_const  (tab_const),
    .cnt        (st_cnt),
    .ovf        (overflow)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic raw_hit;
    sld_entry_cmp #(.OPW(OPW)) u_cmp (
      .st_a    (tab_a[i]),
      .st_b    (tab_b[i]),
      .st_size (tab_size[i]),
      .st_const(tab_const[i]),
      .ld_a    (ld_opa),
      .ld_b    (ld_opb),
      .ld_size (ld_size),
      .ld_const(ld_a_const),
      .hit     (raw_hit)
    );
    assign hit_vec[i] = raw_hit && (CNTW'(i) < st_cnt);
  end

  always_comb conflict_d = ld_valid && (|hit_vec);

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) conflict <= 1'b0;
    else          conflict <= conflict_d;
  end
endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned CNTW  = 3
) (
  input logic            clk,
  input logic            rst_n_i,
  input logic            rec_valid,
  input logic            grp_clear,
  input logic            ld_valid,
  input logic            conflict,
  input logic            overflow,
  input logic [CNTW-1:0] st_cnt
);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n_i)
    !ld_valid |=> !conflict);
  a_r7_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n_i)
    (ld_valid && st_cnt == '0) |=> !conflict);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n_i)
    overflow |=> overflow);
  a_r8_set_full: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rec_valid && !grp_clear && st_cnt == CNTW'(DEPTH)) |=> overflow);
  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n_i)
    st_cnt <= CNTW'(DEPTH));
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n_i)
    grp_clear |=> (st_cnt == CNTW'($past(rec_valid))));
endmodule

bind store_overlap_detector sld_checker #(.DEPTH(DEPTH), .CNTW(CNTW)) u_sld_chk (
  .clk      (clk),
  .rst_n_i  (rst_n_i),
  .rec_valid(rec_valid),
  .grp_clear(grp_clear),
  .ld_valid (ld_valid),
  .conflict (conflict),
  .overflow (overflow),
  .st_cnt   (st_cnt)
);

// File: tb/store_overlap_detector_bench.sv
`timescale 1ns/1ps
module store_overlap_detector_bench;
  localparam int OPW = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           rec_valid, rec_a_const, grp_clear, ld_valid, ld_a_const;
  logic [OPW-1:0] rec_opa, rec_opb, ld_opa, ld_opb;
  logic [2:0]     rec_size, ld_size;
  logic           conflict, overflow;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  store_overlap_detector #(.DEPTH(5), .OPW(OPW)) u_store_overlap_detector (
    .clk(clk), .rst_n(rst_n),
    .rec_valid(rec_valid), .rec_opa(rec_opa), .rec_opb(rec_opb),
    .rec_size(rec_size), .rec_a_const(rec_a_const),
    .grp_clear(grp_clear),
    .ld_valid(ld_valid), .ld_opa(ld_opa), .ld_opb(ld_opb),
    .ld_size(ld_size), .ld_a_const(ld_a_const),
    .conflict(conflict), .overflow(overflow)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic int bytes_of(input int code);
    return (code >= 4) ? 16 : (1 << code);
  endfunction

  function automatic logic overlap_exp(input int so, input int ss, input int lo, input int ls);
    if (so < lo) return (so + ss) > lo;
    return (lo + ls) > so;
  endfunction

  task automatic idle_all();
    rec_valid = 0; grp_clear = 0; ld_valid = 0;
  endtask

  task automatic set_rec(input int a, input int b, input int sz, input logic c);
    rec_valid = 1; rec_opa = OPW'(a); rec_opb = OPW'(b);
    rec_size = 3'(sz); rec_a_const = c;
  endtask

  task automatic set_ld(input int a, input int b, input int sz, input logic c);
    ld_valid = 1; ld_opa = OPW'(a); ld_opb = OPW'(b);
    ld_size = 3'(sz); ld_a_const = c;
  endtask

  // Advance one edge, sample at the following falling edge, return inputs to idle.
  task automatic step();
    @(negedge clk);
    idle_all();
  endtask

  task automatic query(input int a, input int b, input int sz, input logic c,
                       input logic exp, input string tag);
    set_ld(a, b, sz, c);
    step();
    chk(conflict, exp, tag);
  endtask

  task automatic do_reset();
    idle_all();
    rec_opa = '0; rec_opb = '0; rec_size = '0; rec_a_const = 0;
    ld_opa = '0; ld_opb = '0; ld_size = '0; ld_a_const = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(conflict, 1'b0, "R1 conflict after reset");
    chk(overflow, 1'b0, "R1 overflow after reset");

    // R7: empty table never conflicts
    query(100, 7, 2, 0, 1'b0, "R7 empty table");

    // R10: record and query of the same store in one cycle
    set_rec(100, 7, 2, 0);
    set_ld(100, 7, 2, 0);
    step();
    chk(conflict, 1'b0, "R10 same-cycle record invisible");

    // R2: same order match
    query(100, 7, 0, 0, 1'b1, "R2 exact pair");
    // R9: idle cycle after a hit drops conflict
    step();
    chk(conflict, 1'b0, "R9 idle after hit");
    query(100, 8, 2, 0, 1'b0, "R2 base differs");
    query(100, 7, 2, 1, 1'b0, "R2 const flag differs");
    // R3: swapped order
    query(7, 100, 2, 0, 1'b1, "R3 swapped pair");
    query(7, 101, 2, 0, 1'b0, "R3 swapped mismatch");

    // R4/R5 sweep: store at const offset 8, base 3, each store size
    for (int s = 0; s < 8; s++) begin
      grp_clear = 1;
      set_rec(8, 3, s, 1);
      step();
      for (int lo = 0; lo < 32; lo++) begin
        for (int lc = 0; lc < 8; lc++) begin
          query(lo, 3, lc, 1, overlap_exp(8, bytes_of(s), lo, bytes_of(lc)),
                "R4 R5 range sweep");
        end
      end
      query(8, 4, 0, 1, 1'b0, "R4 base differs");
    end

    // R4: top of range, no wrap
    grp_clear = 1;
    set_rec(16'hFFF8, 3, 4, 1);
    step();
    query(16'hFFFF, 3, 0, 1, 1'b1, "R4 end beyond 16 bits");
    query(2, 3, 4, 1, 1'b0, "R4 low offset far below");
    query(16'hFFF0, 3, 3, 1, 1'b0, "R4 adjacent below");
    query(16'hFFF1, 3, 3, 1, 1'b1, "R4 one byte overlap");

    // R8: fill the table, then overflow
    grp_clear = 1;
    step();
    for (int i = 0; i < 5; i++) begin
      set_rec(10 + i, 50, 2, 0);
      step();
    end
    chk(overflow, 1'b0, "R8 full without overflow");
    set_rec(20, 50, 2, 0);
    step();
    chk(overflow, 1'b1, "R8 overflow set");
    query(20, 50, 2, 0, 1'b0, "R8 dropped store ignored");
    query(14, 50, 2, 0, 1'b1, "R8 last entry kept");
    query(10, 50, 2, 0, 1'b1, "R8 first entry kept");

    // R6: query in the clearing cycle sees the old table
    grp_clear = 1;
    set_ld(14, 50, 2, 0);
    step();
    chk(conflict, 1'b1, "R6 clear-cycle query sees old");
    chk(overflow, 1'b1, "R8 overflow sticky over clear");
    query(14, 50, 2, 0, 1'b0, "R6 table emptied");

    // R6: record in the clearing cycle becomes the sole entry
    set_rec(30, 60, 1, 0);
    step();
    grp_clear = 1;
    set_rec(31, 61, 1, 0);
    step();
    query(31, 61, 1, 0, 1'b1, "R6 record during clear kept");
    query(30, 60, 1, 0, 1'b0, "R6 old entry dropped");

    // R1: reset clears sticky overflow and table
    do_reset();
    chk(overflow, 1'b0, "R1 overflow cleared by reset");
    query(31, 61, 1, 0, 1'b0, "R1 table empty after reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule